// File: doc/BRIEF.md
# Delta-Sigma PWM Audio Output

This block turns a 14-bit audio sample into a one-bit output for an external low-pass filter. Each output period is a fixed number of counter steps, 800 by default. During a period the output is high for as many leading steps as the sample's integer part asks for. The upper ten bits of the sample give that integer duty. The lower four bits are a fraction. A first-order noise-shaping accumulator carries the fraction from one period to the next, and its overflow adds one extra step of duty to a period. Over sixteen periods the mean duty therefore matches the full 14-bit value, not only its integer part.

A producer presents a sample together with a valid strobe, and the block holds it. The held sample takes effect only when the next period starts. The block pulses a start-of-period strobe so that the producer can supply the next value in time.

A double-step input lets a clock domain that skips cycles keep the same period in wall-clock time. While it is high, the counter moves two steps per clock, which halves the duty resolution. An integer duty above the period length cannot be shown, so it saturates to a fully-high period and never wraps.

Top module: `pwm_ds_audio`

## Requirements
- R1: During reset and right after it, the audio output is low, the start-of-period strobe is high in the first cycle after reset is released, and the first period after reset has zero high cycles.
- R2: With double-step low, every period lasts exactly PERIOD (800) clocks, and the start-of-period strobe is high for exactly one clock, the first clock of each period.
- R3: In a period the output is high on the first D clocks and low on the rest. D is the duty of that period, either the sample's integer part (bits 13:4) or that value plus one.
- R4: For a constant sample S with integer part below PERIOD, the high cycles of any 16 consecutive periods add up to exactly S. Bits 3:0 are the fraction that the accumulator dithers.
- R5: When the integer part plus the carry exceeds PERIOD, the duty saturates at PERIOD and the output stays high for the whole period, including for sample 0x3FFF.
- R6: A sample accepted in the middle of a period does not change that period's high count. It takes effect from the next period start.
- R7: With double-step high, a period lasts PERIOD/2 clocks, and the high count is ceil(D/2) for the period's duty D.
- R8: While the sample-valid input is low, changes on the sample input have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_i | input | 14 | Audio sample: bits 13:4 integer duty, bits 3:0 fraction |
| sample_vld_i | input | 1 | Loads sample_i into the holding register |
| dbl_step_i | input | 1 | Advance the period counter by two steps per clock |
| audio_o | output | 1 | One-bit PWM audio output |
| new_period_o | output | 1 | High in the first clock of every period |

## Verification
A corrupted period counter shows up within one period, as a wrong period length or a misplaced start strobe. A faulty comparison or clip stage gives a high count outside {int, int+1} in the very next period, and for saturating samples it gives a wrapped, short pulse where a full-high period was due. A fault in the fraction accumulator leaves every single period plausible, so it only shows in the 16-period sum, which then misses the sample value by at least one step. The latching order shows up in the period where a new sample arrives: a fault there changes that period's count to the new sample's duty.

// File: rtl/ads_pkg.sv
// Package: shared defaults for the delta-sigma PWM audio output.
// Assumes: PERIOD is even, so that double stepping divides it exactly.
package ads_pkg;
    parameter int ADS_SAMPLE_W = 14;  // full sample width
    parameter int ADS_FRAC_W   = 4;   // fraction bits that the accumulator dithers
    parameter int ADS_PERIOD   = 800; // counter steps per PWM period
endpackage

// File: rtl/ads_period_cnt.sv
// ads_period_cnt: free-running period counter. It advances one step per clock,
// or two steps when dbl_step is high, and wraps to zero once it would reach
// PERIOD. It flags the last clock of a period (wrap) and the first (start).
// Assumes: PERIOD >= 4 and even.
module ads_period_cnt #(
    parameter int PERIOD = 800,
    parameter int CNT_W  = $clog2(PERIOD)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dbl_step,
    output logic [CNT_W-1:0] cnt_q,
    output logic             wrap,
    output logic             start
);
    logic [CNT_W:0] nxt_w;

    // Next count before wrapping, one bit wider so the compare cannot overflow.
    always_comb begin
        nxt_w = {1'b0, cnt_q} + {{(CNT_W-1){1'b0}}, dbl_step, ~dbl_step};
        wrap  = (nxt_w >= (CNT_W+1)'(PERIOD));
        start = (cnt_q == '0);
    end

    // Counter register: reset to zero, wrap at the end of each period.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (wrap) cnt_q <= '0;
        else           cnt_q <= nxt_w[CNT_W-1:0];
    end

    AST_CNT_RANGE:   assert property (@(posedge clk) disable iff (!rst_n)
                         cnt_q < CNT_W'(PERIOD)); // R2
    AST_WRAP_ZERO:   assert property (@(posedge clk) disable iff (!rst_n)
                         wrap |=> (cnt_q == '0)); // R2
    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
                         start |=> !start); // R2
endmodule

// File: rtl/ads_shaper.sv
// ads_shaper: first-order noise shaper and duty register. At each period
// boundary (load) it adds the fraction to a FRAC_W-bit accumulator, adds the
// carry-out to the integer part, saturates the result at PERIOD and holds it
// as the duty for the coming period.
// Assumes: load is high for exactly the last clock of each period.
module ads_shaper #(
    parameter int SAMPLE_W = 14,
    parameter int FRAC_W   = 4,
    parameter int PERIOD   = 800,
    parameter int DUTY_W   = $clog2(PERIOD + 1),
    parameter int INT_W    = SAMPLE_W - FRAC_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [SAMPLE_W-1:0] samp,
    output logic [DUTY_W-1:0]   duty_q
);
    localparam int RAW_W = INT_W + 1;

    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   frac_sum;
    logic [RAW_W-1:0]  raw_duty;
    logic [DUTY_W-1:0] clip_duty;

    // Fraction sum with its carry, and integer part plus that carry.
    always_comb begin
        frac_sum = {1'b0, acc_q} + {1'b0, samp[FRAC_W-1:0]};
        raw_duty = {1'b0, samp[SAMPLE_W-1:FRAC_W]} + {{INT_W{1'b0}}, frac_sum[FRAC_W]};
    end

    // Saturate only when the integer range can exceed the period length.
    generate
        if ((1 << INT_W) > PERIOD) begin : g_clip
            always_comb begin
                if (raw_duty > RAW_W'(PERIOD)) clip_duty = DUTY_W'(PERIOD);
                else                           clip_duty = DUTY_W'(raw_duty);
            end
        end else begin : g_noclip
            always_comb clip_duty = DUTY_W'(raw_duty);
        end
    endgenerate

    // Accumulator and duty registers, updated once per period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            duty_q <= '0;
        end else if (load) begin
            acc_q  <= frac_sum[FRAC_W-1:0];
            duty_q <= clip_duty;
        end
    end

    AST_DUTY_CLIP: assert property (@(posedge clk) disable iff (!rst_n)
                       duty_q <= DUTY_W'(PERIOD)); // R5
    AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                       !load |=> $stable(duty_q)); // R6
endmodule

// File: rtl/pwm_ds_audio.sv
// pwm_ds_audio: one-bit PWM audio output with delta-sigma fraction dithering.
// Holds the last valid sample, applies it at the next period start, and drives
// the output high while the period counter is below the latched duty.
// Assumes: the sample producer watches new_period_o and may present a sample
// at any time; a sample arriving mid-period waits for the next boundary.
module pwm_ds_audio #(
    parameter int SAMPLE_W = ads_pkg::ADS_SAMPLE_W,
    parameter int FRAC_W   = ads_pkg::ADS_FRAC_W,
    parameter int PERIOD   = ads_pkg::ADS_PERIOD
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic                sample_vld_i,
    input  logic                dbl_step_i,
    output logic                audio_o,
    output logic                new_period_o
);
    localparam int CNT_W  = $clog2(PERIOD);
    localparam int DUTY_W = $clog2(PERIOD + 1);

    logic [SAMPLE_W-1:0] samp_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [DUTY_W-1:0]   duty_q;
    logic                wrap;
    logic                start;

    // Sample holding register, written only by a valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)            samp_q <= '0;
        else if (sample_vld_i) samp_q <= sample_i;
    end

    ads_period_cnt #(.PERIOD(PERIOD), .CNT_W(CNT_W)) i_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .dbl_step (dbl_step_i),
        .cnt_q    (cnt_q),
        .wrap     (wrap),
        .start    (start)
    );

    ads_shaper #(.SAMPLE_W(SAMPLE_W), .FRAC_W(FRAC_W), .PERIOD(PERIOD),
                 .DUTY_W(DUTY_W)) i_shaper (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (wrap),
        .samp   (samp_q),
        .duty_q (duty_q)
    );

    // Output compare against the duty, and the start-of-period strobe.
    always_comb begin
        audio_o      = (DUTY_W'(cnt_q) < duty_q);
        new_period_o = start;
    end

    AST_OUT_FULL:  assert property (@(posedge clk) disable iff (!rst_n)
                       (duty_q == DUTY_W'(PERIOD)) |-> audio_o); // R5
    AST_OUT_ZERO:  assert property (@(posedge clk) disable iff (!rst_n)
                       (duty_q == '0) |-> !audio_o); // R3
    AST_SAMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                       !sample_vld_i |=> $stable(samp_q)); // R8
endmodule

// File: tb/test_pwm_ds_audio.sv
module test_pwm_ds_audio;
    localparam int PERIOD = 800;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] sample_i = '0;
    logic        sample_vld_i = 1'b0;
    logic        dbl_step_i = 1'b0;
    logic        audio_o;
    logic        new_period_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwm_ds_audio i_pwm_ds_audio (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_i     (sample_i),
        .sample_vld_i (sample_vld_i),
        .dbl_step_i   (dbl_step_i),
        .audio_o      (audio_o),
        .new_period_o (new_period_o)
    );

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000 && !done) begin
            n_bad = n_bad + 1;
            $display("FAIL R2 watchdog: actual %0d cycles, expected run end", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input int act, input int lo, input int hi);
        n_cmp++;
        if (act < lo || act > hi) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    // Duty bounds for a sample: integer part, or one more, saturated at PERIOD.
    function automatic int duty_lo(input int s);
        return ((s >> 4) > PERIOD) ? PERIOD : (s >> 4);
    endfunction
    function automatic int duty_hi(input int s);
        return (((s >> 4) + 1) > PERIOD) ? PERIOD : ((s >> 4) + 1);
    endfunction

    // Measure one whole period; called at a negedge, returns at the next strobe.
    task automatic meas(output int hi, output int len);
        while (!new_period_o) @(negedge clk);
        hi = 0;
        len = 0;
        do begin
            if (audio_o) hi++;
            len++;
            @(negedge clk);
        end while (!new_period_o);
    endtask

    task automatic put_sample(input int s);
        sample_i = 14'(s);
        sample_vld_i = 1'b1;
        @(negedge clk);
        sample_vld_i = 1'b0;
    endtask

    // Run 16 periods of a constant sample: per-period bounds and exact sum.
    task automatic run16(input int s);
        int hi, len, sum;
        put_sample(s);
        sum = 0;
        for (int p = 0; p < 16; p++) begin
            meas(hi, len);
            chk("R2 period length", len, PERIOD);
            chk_rng("R3 period duty", hi, duty_lo(s), duty_hi(s));
            sum += hi;
        end
        chk("R4 16-period sum", sum, s);
    endtask

    initial begin
        int hi, len, s, seed_val;
        seed_val = $urandom(32'd7331);

        // R1: reset state
        repeat (4) @(negedge clk);
        chk("R1 audio low in reset", int'(audio_o), 0);
        rst_n = 1'b1;
        chk("R1 strobe after reset", int'(new_period_o), 1);
        chk("R1 audio low after reset", int'(audio_o), 0);
        meas(hi, len);
        chk("R1 first period zero duty", hi, 0);
        chk("R2 first period length", len, PERIOD);

        // R3/R4 directed: zero, exact integer, top unclipped value
        run16(0);
        run16(100 * 16);
        run16(799 * 16 + 15);

        // R3/R4 random samples below the clip range
        for (int k = 0; k < 4; k++) begin
            s = $urandom_range(0, PERIOD * 16 - 1);
            run16(s);
        end

        // R5: saturation, whole period high, no wrap
        put_sample(14'h3FFF);
        for (int p = 0; p < 3; p++) begin
            meas(hi, len);
            chk("R5 full sample saturates", hi, PERIOD);
        end
        put_sample(850 * 16 + 3);
        meas(hi, len);
        chk("R5 above-period sample saturates", hi, PERIOD);

        // R6: sample accepted mid-period applies only from the next period
        put_sample(100 * 16);
        meas(hi, len);
        while (!new_period_o) @(negedge clk);
        hi = 0;
        len = 0;
        do begin
            if (audio_o) hi++;
            len++;
            if (len == 37) begin
                sample_i = 14'(500 * 16);
                sample_vld_i = 1'b1;
            end else begin
                sample_vld_i = 1'b0;
            end
            @(negedge clk);
        end while (!new_period_o);
        chk("R6 current period keeps old sample", hi, 100);
        meas(hi, len);
        chk("R6 new sample at next period", hi, 500);

        // R8: sample input changes without valid are ignored
        sample_i = 14'(20 * 16);
        for (int p = 0; p < 2; p++) begin
            meas(hi, len);
            chk("R8 ignored sample without valid", hi, 500);
        end

        // R7: double stepping halves the period and the duty resolution
        dbl_step_i = 1'b1;
        s = 301 * 16 + 9;
        put_sample(s);
        meas(hi, len);
        for (int p = 0; p < 4; p++) begin
            meas(hi, len);
            chk("R7 double-step period length", len, PERIOD / 2);
            chk_rng("R7 double-step duty", hi, (duty_lo(s) + 1) / 2, (duty_hi(s) + 1) / 2);
        end
        s = 1;
        put_sample(14'(201 * 16));
        meas(hi, len);
        meas(hi, len);
        chk("R7 odd duty rounds up", hi, 101);
        dbl_step_i = 1'b0;

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule